// File: doc/BRIEF.md
# Multiprocessor-Format Serial Receiver

This block receives asynchronous serial frames on a single line. Each frame has one low start bit, eight data bits with the least significant bit first, one address/data marker bit (1 marks an address frame), and one high stop bit. The line is sampled on a sample-enable tick that the surrounding logic supplies at sixteen times the bit rate. Each finished frame is moved into a holding register for the host. The block sets flags for data-ready, framing error and overrun, and it keeps a copy of the marker bit of the last transferred frame.

A wake-up filter lets a node on a shared bus ignore traffic meant for other nodes. While the filter is armed and the marker format is selected, frames with the marker bit at 0 are dropped completely. The first frame with the marker bit at 1 disarms the filter by itself and is then handled like any other frame.

The host uses single-cycle strobes to arm or disarm the filter and to clear each flag. It reads the holding register, the flags and two interrupt requests directly.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset the ready, framing, overrun and marker flags are 0, the filter is disarmed and both interrupt requests are 0.
- R2: A frame that is accepted while ready is 0 loads its eight data bits into `rx_data` (the first bit on the line goes to bit 0), sets `rdy` to 1 and copies its marker bit (the ninth bit on the line) into `mark`.
- R3: A low level that has already ended by the eighth tick after it was first seen starts no frame and sets no flag. A correct frame after it is still received.
- R4: An accepted frame whose stop bit is sampled low sets `ferr`, and its data is still loaded.
- R5: An accepted frame that ends while `rdy` is 1 sets `ovr` and leaves `rx_data` unchanged.
- R6: Each flag falls only on its own clear strobe. If a set event and the clear strobe come in the same cycle, the flag is 1 in the next cycle.
- R7: When `wake_en` is 1 and `mp_mode` is 1, a frame with marker 0 is dropped: it does not change `rx_data` and it sets none of `rdy`, `ferr` or `ovr`. `wake_en` stays 1.
- R8: When `wake_en` is 1 and `mp_mode` is 1, a frame with marker 1 clears `wake_en` and is then handled as in R2, R4 and R5.
- R9: When `mp_mode` is 0, `wake_en` has no effect: every frame is accepted and `wake_en` keeps its value.
- R10: `wake_off` clears `wake_en`. `wake_on` sets it.
- R11: `irq_rx` equals `rdy` AND `rx_ie`. `irq_err` equals (`ferr` OR `ovr`) AND `rx_ie`.
- R12: While `rx_on` is 0 no frame is received, and all flags and `rx_data` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Sample enable at 16x the bit rate |
| rxd | input | 1 | Serial input line, idles high |
| rx_on | input | 1 | Receiver enable |
| mp_mode | input | 1 | Selects the marker (multiprocessor) format |
| rx_ie | input | 1 | Interrupt enable for both requests |
| wake_on | input | 1 | Strobe that arms the wake-up filter |
| wake_off | input | 1 | Strobe that disarms the wake-up filter |
| clr_rdy | input | 1 | Strobe that clears the ready flag |
| clr_ferr | input | 1 | Strobe that clears the framing-error flag |
| clr_ovr | input | 1 | Strobe that clears the overrun flag |
| rx_data | output | 8 | Received data register |
| rdy | output | 1 | Data-ready flag |
| ferr | output | 1 | Framing-error flag |
| ovr | output | 1 | Overrun flag |
| mark | output | 1 | Marker bit of the last transferred frame |
| wake_en | output | 1 | Wake-up filter armed |
| irq_rx | output | 1 | Receive interrupt request |
| irq_err | output | 1 | Error interrupt request |

## Verification
Two things can happen in the same cycle: a flag being set by the end of a frame, and the host clearing that same flag. The bench holds the clear strobes for `rdy` and `ferr` high during a whole frame whose stop bit is low. This puts the set event inside the clear window without the bench needing to know the exact cycle. A monitor watches at every falling edge whether each flag was seen high. A correct design shows each flag high for at least one cycle and then low again once the strobe is held. A design where the clear wins never shows the flag high.

// File: rtl/mprx_pkg.sv
package mprx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/mprx_deframer.sv
module mprx_deframer
  import mprx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              rxd_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              mark_o,
  output logic              stop_o
);
  localparam int NBITS = DATA_W + 1;
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(NBITS + 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line;
  rx_state_t              state_q, state_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [IDX_W-1:0]       idx_q, idx_d;
  logic [NBITS-1:0]       shf_q, shf_d;
  logic                   stop_q, stop_d;
  logic                   done_q, done_d;

  assign line = sync_q[SYNC_STAGES-1];

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    shf_d   = shf_q;
    stop_d  = stop_q;
    done_d  = 1'b0;
    if (!en_i) begin
      state_d = RX_IDLE;
    end else if (tick_i) begin
      unique case (state_q)
        RX_IDLE: if (!line) begin
          state_d = RX_START;
          cnt_d   = '0;
        end
        RX_START: if (cnt_q == MID) begin
          cnt_d   = '0;
          idx_d   = '0;
          state_d = line ? RX_IDLE : RX_BITS;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        RX_BITS: if (cnt_q == LAST) begin
          cnt_d = '0;
          shf_d = {line, shf_q[NBITS-1:1]};
          idx_d = idx_q + 1'b1;
          if (idx_q == IDX_W'(NBITS - 1)) state_d = RX_STOP;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        RX_STOP: if (cnt_q == LAST) begin
          done_d  = 1'b1;
          stop_d  = line;
          state_d = RX_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shf_q   <= '0;
      stop_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], rxd_i};
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      shf_q   <= shf_d;
      stop_q  <= stop_d;
      done_q  <= done_d;
    end
  end

  assign done_o = done_q;
  assign data_o = shf_q[DATA_W-1:0];
  assign mark_o = shf_q[NBITS-1];
  assign stop_o = stop_q;

  // R12: the receiver drops back to idle while it is disabled
  a_r12_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> state_q == RX_IDLE);
  // R3: the end of a frame is signalled for one cycle only
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/mprx_flags.sv
module mprx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mark_i,
  input  logic              stop_i,
  input  logic              mp_mode_i,
  input  logic              wake_on_i,
  input  logic              wake_off_i,
  input  logic              clr_rdy_i,
  input  logic              clr_ferr_i,
  input  logic              clr_ovr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              rdy_o,
  output logic              ferr_o,
  output logic              ovr_o,
  output logic              mark_o,
  output logic              wake_o
);
  logic              filt, accept, load;
  logic              rdy_q, rdy_d, ferr_q, ferr_d, ovr_q, ovr_d;
  logic              mark_q, wake_q, wake_d;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    filt   = wake_q & mp_mode_i;
    accept = done_i & (~filt | mark_i);
    load   = accept & ~rdy_q;
    rdy_d  = load | (rdy_q & ~clr_rdy_i);
    ferr_d = (accept & ~stop_i) | (ferr_q & ~clr_ferr_i);
    ovr_d  = (accept & rdy_q) | (ovr_q & ~clr_ovr_i);
    if (wake_off_i || (done_i && filt && mark_i)) wake_d = 1'b0;
    else if (wake_on_i)                            wake_d = 1'b1;
    else                                           wake_d = wake_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      ferr_q <= 1'b0;
      ovr_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      rdy_q  <= rdy_d;
      ferr_q <= ferr_d;
      ovr_q  <= ovr_d;
      wake_q <= wake_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mark_q <= 1'b0;
    end else if (load) begin
      data_q <= data_i;
      mark_q <= mark_i;
    end
  end

  assign data_o = data_q;
  assign rdy_o  = rdy_q;
  assign ferr_o = ferr_q;
  assign ovr_o  = ovr_q;
  assign mark_o = mark_q;
  assign wake_o = wake_q;

  // R7: a frame dropped by the filter raises no flag
  a_r7_filter_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && wake_q && mp_mode_i && !mark_i) |=>
      !$rose(rdy_q) && !$rose(ferr_q) && !$rose(ovr_q));
  // R8: an address frame disarms the filter
  a_r8_wake_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && wake_q && mp_mode_i && mark_i) |=> !wake_q);
  // R5: an overrun keeps the old data
  a_r5_ovr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && rdy_q && !(wake_q && mp_mode_i && !mark_i)) |=> ovr_q && $stable(data_q));
  // R6: a set event beats the clear strobe
  a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !rdy_q && !(wake_q && mp_mode_i)) |=> rdy_q);
  // R10: the host can disarm the filter
  a_r10_host_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wake_off_i |=> !wake_q);
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              rx_on,
  input  logic              mp_mode,
  input  logic              rx_ie,
  input  logic              wake_on,
  input  logic              wake_off,
  input  logic              clr_rdy,
  input  logic              clr_ferr,
  input  logic              clr_ovr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rdy,
  output logic              ferr,
  output logic              ovr,
  output logic              mark,
  output logic              wake_en,
  output logic              irq_rx,
  output logic              irq_err
);
  logic              f_done, f_mark, f_stop;
  logic [DATA_W-1:0] f_data;

  mprx_deframer #(.DATA_W(DATA_W), .OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_deframe (
    .clk(clk), .rst_n(rst_n), .tick_i(os_tick), .en_i(rx_on), .rxd_i(rxd),
    .done_o(f_done), .data_o(f_data), .mark_o(f_mark), .stop_o(f_stop)
  );

  mprx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .done_i(f_done), .data_i(f_data), .mark_i(f_mark),
    .stop_i(f_stop), .mp_mode_i(mp_mode), .wake_on_i(wake_on), .wake_off_i(wake_off),
    .clr_rdy_i(clr_rdy), .clr_ferr_i(clr_ferr), .clr_ovr_i(clr_ovr),
    .data_o(rx_data), .rdy_o(rdy), .ferr_o(ferr), .ovr_o(ovr), .mark_o(mark),
    .wake_o(wake_en)
  );

  assign irq_rx  = rdy & rx_ie;
  assign irq_err = (ferr | ovr) & rx_ie;

  // R11: no interrupt request while interrupts are disabled
  a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ie |-> !irq_rx && !irq_err);
endmodule

// File: tb/mp_uart_rx_test.sv
module mp_uart_rx_test;
  localparam int TDIV = 2;
  localparam int BITCLK = 16 * TDIV;

  logic clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rxd = 1'b1;
  logic rx_on = 1'b0, mp_mode = 1'b0, rx_ie = 1'b0, wake_on = 1'b0, wake_off = 1'b0;
  logic clr_rdy = 1'b0, clr_ferr = 1'b0, clr_ovr = 1'b0;
  logic [7:0] rx_data;
  logic rdy, ferr, ovr, mark, wake_en, irq_rx, irq_err;
  int total = 0, bad = 0, tdiv_cnt = 0;
  logic mon_on = 1'b0, seen_rdy = 1'b0, seen_ferr = 1'b0;

  mp_uart_rx uut (.*);

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tdiv_cnt <= (tdiv_cnt + 1) % TDIV;
    os_tick  <= (tdiv_cnt == 0);
    if (mon_on && rdy)  seen_rdy  <= 1'b1;
    if (mon_on && ferr) seen_ferr <= 1'b1;
  end

  // each entry: data[12:5] mark[4] stop[3] mp_mode[2] wake[1] accepted[0]
  localparam logic [12:0] VEC [9] = '{
    {8'hA5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'h3C, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {8'h5A, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'hC3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    {8'h77, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'h81, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h18, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) rxd = b;
    repeat (BITCLK - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic m, input logic s);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    send_bit(m);
    send_bit(s);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic pulse_clears();
    @(negedge clk) begin clr_rdy = 1'b1; clr_ferr = 1'b1; clr_ovr = 1'b1; end
    @(negedge clk) begin clr_rdy = 1'b0; clr_ferr = 1'b0; clr_ovr = 1'b0; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    logic exp_wake;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rdy", rdy, 0);
    chk("R1 ferr", ferr, 0);
    chk("R1 ovr", ovr, 0);
    chk("R1 mark", mark, 0);
    chk("R1 wake_en", wake_en, 0);
    chk("R1 irqs", {irq_rx, irq_err}, 0);
    rx_on = 1'b1;

    // vector table
    for (int k = 0; k < 9; k++) begin
      pulse_clears();
      @(negedge clk) wake_off = 1'b1;
      @(negedge clk) wake_off = 1'b0;
      if (VEC[k][1]) begin
        @(negedge clk) wake_on = 1'b1;
        @(negedge clk) wake_on = 1'b0;
      end
      mp_mode = VEC[k][2];
      prev = rx_data;
      send_frame(VEC[k][12:5], VEC[k][4], VEC[k][3]);
      exp_wake = VEC[k][2] ? (VEC[k][1] & ~VEC[k][4]) : VEC[k][1];
      chk("R2/R7 rdy", rdy, VEC[k][0]);
      chk("R2/R7 data", rx_data, VEC[k][0] ? VEC[k][12:5] : prev);
      chk("R4/R7 ferr", ferr, VEC[k][0] & ~VEC[k][3]);
      chk("R7 ovr", ovr, 0);
      if (VEC[k][0]) chk("R2 mark", mark, VEC[k][4]);
      chk("R8/R9 wake_en", wake_en, exp_wake);
    end

    // R6 plain clear
    pulse_clears();
    chk("R6 clear rdy", rdy, 0);
    chk("R6 clear ferr", ferr, 0);
    mp_mode = 1'b0;

    // R3 glitch
    @(negedge clk) rxd = 1'b0;
    repeat (5 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (BITCLK * 12) @(negedge clk);
    chk("R3 glitch rdy", rdy, 0);
    send_frame(8'h96, 1'b0, 1'b1);
    chk("R3 after glitch data", rx_data, 8'h96);
    chk("R3 after glitch rdy", rdy, 1);

    // R11 and R5 overrun
    rx_ie = 1'b1;
    @(negedge clk);
    chk("R11 irq_rx", irq_rx, 1);
    chk("R11 irq_err idle", irq_err, 0);
    send_frame(8'h4B, 1'b1, 1'b1);
    chk("R5 ovr", ovr, 1);
    chk("R5 data kept", rx_data, 8'h96);
    chk("R5 mark kept", mark, 0);
    chk("R11 irq_err", irq_err, 1);
    rx_ie = 1'b0;
    @(negedge clk);
    chk("R11 gated", {irq_rx, irq_err}, 0);

    // R12 disabled receiver keeps flags
    rx_on = 1'b0;
    send_frame(8'h11, 1'b0, 1'b0);
    chk("R12 rdy kept", rdy, 1);
    chk("R12 ovr kept", ovr, 1);
    chk("R12 ferr", ferr, 0);
    chk("R12 data kept", rx_data, 8'h96);
    rx_on = 1'b1;
    pulse_clears();

    // R6 set and clear in the same cycle
    @(negedge clk) begin clr_rdy = 1'b1; clr_ferr = 1'b1; mon_on = 1'b1; end
    send_frame(8'h2D, 1'b0, 1'b0);
    @(negedge clk) begin clr_rdy = 1'b0; clr_ferr = 1'b0; mon_on = 1'b0; end
    chk("R6 rdy set wins", seen_rdy, 1);
    chk("R6 ferr set wins", seen_ferr, 1);
    chk("R6 rdy cleared", rdy, 0);
    chk("R6 data loaded", rx_data, 8'h2D);

    // R10 host disarm
    @(negedge clk) wake_on = 1'b1;
    @(negedge clk) wake_on = 1'b0;
    chk("R10 armed", wake_en, 1);
    @(negedge clk) wake_off = 1'b1;
    @(negedge clk) wake_off = 1'b0;
    chk("R10 disarmed", wake_en, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule